// File: doc/BRIEF.md
# Write-through cache invalidation controller

This block holds the tag and valid state, plus one data word per line, of a small direct-mapped data cache that runs in write-through mode. The CPU side presents a load or a store on each cycle. A load looks up its line in the same cycle and reports a hit. A store writes its line and is also put on the memory bus in that same cycle. A separate fill port lets the refill logic install a line after a load has missed.

A translation-miss flag arrives with every CPU access. When it is set, a store must not leave modified data in the cache. The block blocks the bus write and clears the line's valid bit, so the next read goes to memory.

A single control-register write port handles invalidation. With the top bit set, the write clears one line in one cycle. With the top bit clear, it starts a hardware sweep that clears every line in turn, and the CPU port is stalled while the sweep runs.

Top module: `wtc_ctrl`

## Requirements
- R1: After reset, every line is invalid, so every load misses, and `cpu_stall` is low.
- R2: A load with `cpu_req`=1, `cpu_we`=0 and `tlb_miss`=0 reports `cpu_hit`=1 in the same cycle when its line is valid and the stored tag matches. Otherwise `cpu_hit` is 0. `cpu_rdata` holds the line's word on a hit. The line index is `cpu_addr[OFF_W+IDX_W-1:OFF_W]` and the tag is `cpu_addr[AW-1:OFF_W+IDX_W]`.
- R3: An accepted store (`cpu_req`=1, `cpu_we`=1, `tlb_miss`=0, not stalled) drives `mem_we`=1, `mem_addr`=`cpu_addr` and `mem_wdata`=`cpu_wdata` in the same cycle. At the clock edge it also writes tag, data and valid into its line, so a later load of that address hits with that data.
- R4: `fill_we` installs `fill_addr`/`fill_data` as a valid line at the clock edge. The fill is ignored in a cycle that has an accepted store.
- R5: A store with `tlb_miss`=1 drives no `mem_we`, writes no data and clears its line's valid bit. A load with `tlb_miss`=1 never hits.
- R6: A control write (`csr_we`) with bit 31 set clears only the line whose index is `csr_wdata[IDX_W-1:0]`. It takes effect at that clock edge and ignores bits 30 down to IDX_W. It does not raise `cpu_stall`, and other lines keep their state.
- R7: A control write with bit 31 clear starts a full flush and ignores all other bits. `cpu_stall` rises in the next cycle and stays high for exactly 2^IDX_W cycles. Once it drops, every line is invalid.
- R8: While `cpu_stall` is high, CPU accesses, fills and control writes are ignored: there is no `mem_we`, no hit, and no change to any line.
- R9: If a single-line invalidate and an accepted store target the same index in the same cycle, the invalidate wins and the line ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Store data |
| tlb_miss | input | 1 | Translation for this access missed |
| cpu_stall | output | 1 | Flush in progress; CPU access not accepted |
| cpu_hit | output | 1 | Load hit this cycle |
| cpu_rdata | output | DW | Data word of the looked-up line |
| mem_we | output | 1 | Write-through bus write strobe |
| mem_addr | output | AW | Bus write address |
| mem_wdata | output | DW | Bus write data |
| fill_we | input | 1 | Refill write strobe |
| fill_addr | input | AW | Refill address |
| fill_data | input | DW | Refill data |
| csr_we | input | 1 | Invalidation control register write |
| csr_wdata | input | 32 | Control value (bit 31 selects single line) |

## Verification
The hardest case to reach from the ports is the CPU port during a flush that is already running. Loads, stores, fills and control writes all have to be shown to do nothing while a sweep is part-way through. To get there, the bench first fills every line, then starts a flush. Partway through the sweep it issues a store and a fill, and later a load aimed at a line the sweep has not yet reached. A second hard case is a same-cycle collision. A store and a single-line invalidate are driven on the same index in one cycle, and a store is driven together with a fill. After each collision a load sweep shows which of the two won.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int CTL_SEL_BIT = 31;

  typedef enum logic [1:0] {
    CTL_NONE = 2'd0,
    CTL_LINE = 2'd1,
    CTL_ALL  = 2'd2
  } ctl_op_e;

  // Bit 31 set: one line; clear: whole cache.
  function automatic ctl_op_e ctl_decode(input logic we, input logic [31:0] val);
    if (!we) return CTL_NONE;
    return val[CTL_SEL_BIT] ? CTL_LINE : CTL_ALL;
  endfunction
endpackage

// File: rtl/wtc_flush_seq.sv
module wtc_flush_seq #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] step_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy     = busy_q;
  assign step_idx = cnt_q;
endmodule

// File: rtl/wtc_valid_store.sv
module wtc_valid_store #(
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr_line_en,
  input  logic [IDX_W-1:0]      clr_line_idx,
  input  logic                  clr_step_en,
  input  logic [IDX_W-1:0]      clr_step_idx,
  input  logic                  clr_tlb_en,
  input  logic [IDX_W-1:0]      clr_tlb_idx,
  output logic [(1<<IDX_W)-1:0] valid_vec
);
  localparam int LINES = 1 << IDX_W;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic clr_hit;
    logic set_hit;
    assign clr_hit = (clr_line_en && clr_line_idx == IDX_W'(g))
                   || (clr_step_en && clr_step_idx == IDX_W'(g))
                   || (clr_tlb_en  && clr_tlb_idx  == IDX_W'(g));
    assign set_hit = set_en && set_idx == IDX_W'(g);

    // Clearing wins over setting (R9).
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_vec[g] <= 1'b0;
      else if (clr_hit) valid_vec[g] <= 1'b0;
      else if (set_hit) valid_vec[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/wtc_tag_data.sv
module wtc_tag_data #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [TAG_W-1:0] wtag,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [TAG_W-1:0] rtag,
  output logic [DW-1:0]    rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem  [LINES];
  logic [DW-1:0]    data_mem [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx]  <= wtag;
      data_mem[widx] <= wdata;
    end
  end

  assign rtag  = tag_mem[ridx];
  assign rdata = data_mem[ridx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 4,
  parameter int OFF_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          tlb_miss,
  output logic          cpu_stall,
  output logic          cpu_hit,
  output logic [DW-1:0] cpu_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          csr_we,
  input  logic [31:0]   csr_wdata
);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam int LINES = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] line_idx(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [AW-1:0] a);
    return a[AW-1 -: TAG_W];
  endfunction

  // Named internal events
  ctl_op_e          ctl_op;
  logic             busy;
  logic [IDX_W-1:0] step_idx;
  logic             accept;
  logic             st_evt;
  logic             tlb_clr_evt;
  logic             ld_evt;
  logic             line_inv_evt;
  logic             flush_start_evt;
  logic             flush_step_evt;
  logic             fill_evt;
  logic             set_evt;
  logic [IDX_W-1:0] cidx;
  logic [TAG_W-1:0] ctag;
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] set_tag;
  logic [DW-1:0]    set_data;
  logic [TAG_W-1:0] rtag;
  logic [LINES-1:0] valid_vec;

  assign ctl_op          = ctl_decode(csr_we, csr_wdata);
  assign cidx            = line_idx(cpu_addr);
  assign ctag            = line_tag(cpu_addr);
  assign accept          = cpu_req && !busy;                         // R8
  assign st_evt          = accept && cpu_we && !tlb_miss;            // R3
  assign tlb_clr_evt     = accept && cpu_we && tlb_miss;             // R5
  assign ld_evt          = accept && !cpu_we && !tlb_miss;           // R2
  assign line_inv_evt    = !busy && ctl_op == CTL_LINE;              // R6
  assign flush_start_evt = !busy && ctl_op == CTL_ALL;               // R7
  assign flush_step_evt  = busy;
  assign fill_evt        = !busy && fill_we && !st_evt;              // R4
  assign set_evt         = st_evt || fill_evt;

  assign set_idx  = st_evt ? cidx      : line_idx(fill_addr);
  assign set_tag  = st_evt ? ctag      : line_tag(fill_addr);
  assign set_data = st_evt ? cpu_wdata : fill_data;

  wtc_flush_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (flush_start_evt),
    .busy     (busy),
    .step_idx (step_idx)
  );

  wtc_valid_store #(.IDX_W(IDX_W)) u_valid (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_en       (set_evt),
    .set_idx      (set_idx),
    .clr_line_en  (line_inv_evt),
    .clr_line_idx (csr_wdata[IDX_W-1:0]),
    .clr_step_en  (flush_step_evt),
    .clr_step_idx (step_idx),
    .clr_tlb_en   (tlb_clr_evt),
    .clr_tlb_idx  (cidx),
    .valid_vec    (valid_vec)
  );

  wtc_tag_data #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk   (clk),
    .we    (set_evt),
    .widx  (set_idx),
    .wtag  (set_tag),
    .wdata (set_data),
    .ridx  (cidx),
    .rtag  (rtag),
    .rdata (cpu_rdata)
  );

  assign cpu_stall = busy;
  assign cpu_hit   = ld_evt && valid_vec[cidx] && rtag == ctag;
  assign mem_we    = st_evt;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
endmodule

// File: rtl/wtc_ctrl_chk.sv
module wtc_ctrl_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 4,
  parameter int OFF_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_req,
  input logic                  cpu_we,
  input logic [AW-1:0]         cpu_addr,
  input logic [DW-1:0]         cpu_wdata,
  input logic                  tlb_miss,
  input logic                  cpu_stall,
  input logic                  cpu_hit,
  input logic                  mem_we,
  input logic [AW-1:0]         mem_addr,
  input logic [DW-1:0]         mem_wdata,
  input logic                  csr_we,
  input logic [31:0]           csr_wdata,
  input logic                  line_inv_evt,
  input logic [(1<<IDX_W)-1:0] valid_vec
);
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] cidx;
  logic             store_ok;
  logic [IDX_W+1:0] run_len;

  assign cidx     = cpu_addr[OFF_W +: IDX_W];
  assign store_ok = cpu_req && cpu_we && !tlb_miss && !cpu_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (cpu_stall) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> valid_vec == '0 && !cpu_stall);

  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> valid_vec[cidx] && cpu_req && !cpu_we && !tlb_miss);

  a_r3_bus_forward: assert property (@(posedge clk) disable iff (!rst_n)
    store_ok |-> mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata);

  a_r3_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (store_ok && !line_inv_evt) |=> valid_vec[$past(cidx)]);

  a_r5_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && tlb_miss) |-> !mem_we);

  a_r5_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && tlb_miss && !cpu_stall) |=> !valid_vec[$past(cidx)]);

  a_r6_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[31] && !cpu_stall) |=> !cpu_stall && !valid_vec[$past(csr_wdata[IDX_W-1:0])]);

  a_r7_flush_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_wdata[31] && !cpu_stall) |=> cpu_stall);

  a_r7_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> run_len == (IDX_W+2)'(LINES) && valid_vec == '0);

  a_r8_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !mem_we && !cpu_hit);

  a_r8_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> (valid_vec & ~$past(valid_vec)) == '0);
endmodule

bind wtc_ctrl wtc_ctrl_chk #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .cpu_wdata    (cpu_wdata),
  .tlb_miss     (tlb_miss),
  .cpu_stall    (cpu_stall),
  .cpu_hit      (cpu_hit),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .csr_we       (csr_we),
  .csr_wdata    (csr_wdata),
  .line_inv_evt (line_inv_evt),
  .valid_vec    (valid_vec)
);

// File: tb/sim_wtc_ctrl.sv
module sim_wtc_ctrl;
  localparam int AW = 32, DW = 32, IDX_W = 4, OFF_W = 2;
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req, cpu_we, tlb_miss, fill_we, csr_we;
  logic [AW-1:0] cpu_addr, fill_addr, mem_addr;
  logic [DW-1:0] cpu_wdata, fill_data, cpu_rdata, mem_wdata;
  logic [31:0] csr_wdata;
  logic cpu_stall, cpu_hit, mem_we;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  bit               mv [LINES];
  logic [TAG_W-1:0] mt [LINES];
  logic [DW-1:0]    md [LINES];

  always #10 clk = ~clk;

  wtc_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .tlb_miss(tlb_miss), .cpu_stall(cpu_stall), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .csr_we(csr_we), .csr_wdata(csr_wdata));

  function automatic logic [AW-1:0] mk(input logic [TAG_W-1:0] t, input int i);
    return {t, i[IDX_W-1:0], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [TAG_W-1:0] tag_for(input int i, input int salt);
    return TAG_W'(i * 37 + salt);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_req = 0; cpu_we = 0; tlb_miss = 0; cpu_addr = '0; cpu_wdata = '0;
    fill_we = 0; fill_addr = '0; fill_data = '0; csr_we = 0; csr_wdata = '0;
  endtask

  task automatic load(input logic [AW-1:0] a, input bit tm, input string req);
    int i;
    bit exp;
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = a; tlb_miss = tm;
    #5;
    i = int'(a[OFF_W +: IDX_W]);
    exp = mv[i] && mt[i] == a[AW-1 -: TAG_W] && !tm;
    chk(cpu_hit == exp, req, 64'(cpu_hit), 64'(exp));
    if (exp) chk(cpu_rdata == md[i], req, 64'(cpu_rdata), 64'(md[i]));
    @(posedge clk); #1 idle();
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit tm, input string req);
    int i;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d; tlb_miss = tm;
    #5;
    chk(mem_we == !tm, req, 64'(mem_we), 64'(!tm));
    if (!tm) chk(mem_addr == a && mem_wdata == d, req, {mem_addr, mem_wdata}, {a, d});
    @(posedge clk); #1 idle();
    i = int'(a[OFF_W +: IDX_W]);
    if (tm) mv[i] = 0;
    else begin mv[i] = 1; mt[i] = a[AW-1 -: TAG_W]; md[i] = d; end
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int i;
    @(negedge clk);
    fill_we = 1; fill_addr = a; fill_data = d;
    @(posedge clk); #1 idle();
    i = int'(a[OFF_W +: IDX_W]);
    mv[i] = 1; mt[i] = a[AW-1 -: TAG_W]; md[i] = d;
  endtask

  task automatic sweep(input int salt, input string req);
    for (int i = 0; i < LINES; i++) load(mk(tag_for(i, salt), i), 0, req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cnt;
    idle();
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(cpu_stall == 0, "R1", 64'(cpu_stall), 0);
    for (int i = 0; i < LINES; i++) load(mk('0, i), 0, "R1");

    // R3 / R2: fill every line via stores, hit and mismatched-tag miss
    for (int i = 0; i < LINES; i++) store(mk(tag_for(i, 5), i), DW'(32'hA000_0000 + i * 17), 0, "R3");
    sweep(5, "R3");
    sweep(9, "R2");

    // R6: single-line invalidate of odd lines, junk in ignored bits
    for (int i = 1; i < LINES; i += 2) begin
      @(negedge clk);
      csr_we = 1; csr_wdata = 32'hFFFF_FFF0 | 32'(i);
      @(posedge clk); #1 idle();
      chk(cpu_stall == 0, "R6", 64'(cpu_stall), 0);
      mv[i] = 0;
    end
    sweep(5, "R6");

    // R4: refill odd lines, then fill colliding with a store
    for (int i = 1; i < LINES; i += 2) fill(mk(tag_for(i, 11), i), DW'(32'h5500_0000 + i));
    sweep(11, "R4");
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = mk(tag_for(4, 21), 4); cpu_wdata = 32'hC0DE_0004;
    fill_we = 1; fill_addr = mk(tag_for(6, 22), 6); fill_data = 32'hBAD0_0006;
    @(posedge clk); #1 idle();
    mv[4] = 1; mt[4] = tag_for(4, 21); md[4] = 32'hC0DE_0004;
    load(mk(tag_for(4, 21), 4), 0, "R4");
    load(mk(tag_for(6, 22), 6), 0, "R4");
    load(mk(tag_for(6, 5), 6), 0, "R4");

    // R5: translation miss on store and on load
    store(mk(tag_for(2, 30), 2), 32'hDEAD_0002, 1, "R5");
    load(mk(tag_for(2, 30), 2), 0, "R5");
    load(mk(tag_for(2, 5), 2), 0, "R5");
    load(mk(tag_for(8, 5), 8), 1, "R5");
    load(mk(tag_for(8, 5), 8), 0, "R5");

    // R9: store and single-line invalidate on the same index
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = mk(tag_for(3, 40), 3); cpu_wdata = 32'h0000_3333;
    csr_we = 1; csr_wdata = 32'h8000_0003;
    @(posedge clk); #1 idle();
    mv[3] = 0;
    load(mk(tag_for(3, 40), 3), 0, "R9");

    // R7 / R8: full flush with junk in ignored bits
    for (int i = 0; i < LINES; i++) store(mk(tag_for(i, 50), i), DW'(i * 3 + 1), 0, "R3");
    @(negedge clk);
    csr_we = 1; csr_wdata = 32'h1234_5678;
    @(posedge clk); #1 idle();
    cnt = 0;
    @(negedge clk);
    while (cpu_stall && cnt < 100) begin
      cnt++;
      if (cnt == 2) begin
        cpu_req = 1; cpu_we = 1; cpu_addr = mk(tag_for(0, 60), 0); cpu_wdata = 32'h7777_7777;
        fill_we = 1; fill_addr = mk(tag_for(1, 61), 1); fill_data = 32'h6666_6666;
        csr_we = 1; csr_wdata = 32'h8000_000F;
        #5;
        chk(mem_we == 0, "R8", 64'(mem_we), 0);
      end
      if (cnt == 3) begin
        cpu_req = 1; cpu_we = 0; cpu_addr = mk(tag_for(15, 50), 15);
        #5;
        chk(cpu_hit == 0, "R8", 64'(cpu_hit), 0);
      end
      @(negedge clk); idle();
    end
    chk(cnt == LINES, "R7", 64'(cnt), 64'(LINES));
    for (int i = 0; i < LINES; i++) mv[i] = 0;
    sweep(50, "R7");
    load(mk(tag_for(0, 60), 0), 0, "R8");
    load(mk(tag_for(1, 61), 1), 0, "R8");

    // After a flush, stores allocate again
    store(mk(tag_for(7, 70), 7), 32'h0000_7070, 0, "R3");
    load(mk(tag_for(7, 70), 7), 0, "R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule